// File: doc/BRIEF.md
# Binary Tape Register With Movable Head

This block is a bit-serial tape memory. A fixed-depth array of single-bit cells is accessed through a head pointer that moves one cell at a time. A sequencer drives one-cycle command pulses: step forward, step back, read, write one and write zero. The block answers each command that produces a result with a zero/non-zero bit (Z/NZ) and a one-cycle valid strobe.

Reads are destructive. A read returns the bit under the head and clears that cell. The caller must then restore a value with an explicit write at the same position. A high-water mark records the furthest cell the head has reached. A forward step therefore reports whether the head entered a cell that has never been visited. Stepping past the last cell saturates and raises an overflow flag. Writing without a pending read raises a protocol-error flag. Both flags stay set until reset. All cells start at zero.

Top module: `tape_head_reg`

## Requirements
- R1: After reset the head is at cell 0, the high-water mark is 0, every cell holds 0, resValid is low and both flags are low. Both flags can only be cleared by reset.
- R2: A step-forward command that is not at the last cell moves the head to head+1. It returns NZ when head+1 lies beyond the high-water mark and Z otherwise. When the new cell lies beyond the mark, the mark moves to head+1.
- R3: A step-forward command at cell DEPTH-1 leaves the head in place, returns Z and sets ovfFlag.
- R4: A step-back command moves the head to head-1 and returns NZ. At cell 0 the head stays at 0 and the command returns Z.
- R5: A read command returns NZ when the cell under the head holds 1 and Z when it holds 0.
- R6: A read command clears the cell under the head. A second read with no write in between returns Z.
- R7: When a read is pending at the head, a set command stores 1 and a reset command stores 0. Neither command produces a result, so resValid stays low.
- R8: A read stays pending only until the next write or the next step command. A set or reset with no pending read leaves the tape unchanged and sets protoErr.
- R9: resValid is high for exactly the one cycle after each step-forward, step-back or read command. resNz is valid in that same cycle. resValid is low in every other cycle.
- R10: When several command pulses arrive in the same cycle, only one takes effect, in this priority order: step-forward, step-back, read, set, reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdInc | input | 1 | Step-forward pulse |
| cmdDec | input | 1 | Step-back pulse |
| cmdRead | input | 1 | Destructive read pulse |
| cmdSet | input | 1 | Write-one pulse |
| cmdReset | input | 1 | Write-zero pulse |
| resValid | output | 1 | Result strobe, one cycle after a result-producing command |
| resNz | output | 1 | Result bit, 1 = NZ, 0 = Z |
| headPos | output | $clog2(DEPTH) | Current head cell |
| ovfFlag | output | 1 | Sticky: a forward step was attempted at the last cell |
| protoErr | output | 1 | Sticky: a write arrived without a pending read |

## Verification
Every registered result is due in the cycle after its command. The command is sampled at one rising edge, and resValid, resNz, headPos and the flags all change at that same edge. The bench drives each pulse for one cycle starting at a falling edge. It samples at the next falling edge, which follows the capturing rising edge, so each check sees the result exactly one register stage after its stimulus. The bench reads cell contents only through later reads, and it observes the effect of ignored writes the same way.

// File: rtl/tape_pkg.sv
package tape_pkg;
  typedef struct packed {
    logic doInc;
    logic doDec;
    logic doRead;
    logic doWrite;
    logic wrVal;
  } tape_strobe_t;

  localparam int NUM_CMDS = 5;
  localparam int CMD_INC = 0;
  localparam int CMD_DEC = 1;
  localparam int CMD_RD  = 2;
  localparam int CMD_SET = 3;
  localparam int CMD_CLR = 4;
endpackage

// File: rtl/tape_dpath.sv
module tape_dpath #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tape_pkg::tape_strobe_t strb,
  output logic [AW-1:0]          headPos,
  output logic                   atFirst,
  output logic                   atLast,
  output logic                   nextFresh,
  output logic                   curBit
);
  localparam logic [AW-1:0] LAST_CELL = AW'(DEPTH - 1);

  logic [AW-1:0]    headQ, hwmQ;
  logic [DEPTH-1:0] tapeQ;
  logic [AW:0]      headPlusOne;

  assign headPlusOne = {1'b0, headQ} + 1'b1;
  assign atFirst   = (headQ == '0);
  assign atLast    = (headQ == LAST_CELL);
  assign nextFresh = headPlusOne > {1'b0, hwmQ};
  assign curBit    = tapeQ[headQ];
  assign headPos   = headQ;

  // head pointer and high-water mark
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      hwmQ  <= '0;
    end else if (strb.doInc && !atLast) begin
      headQ <= headPlusOne[AW-1:0];
      if (nextFresh) hwmQ <= headPlusOne[AW-1:0];
    end else if (strb.doDec && !atFirst) begin
      headQ <= headQ - 1'b1;
    end
  end

  // one storage cell per tape position
  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    logic hit;
    assign hit = (headQ == AW'(c));
    always_ff @(posedge clk) begin
      if (!rstN)                    tapeQ[c] <= 1'b0;
      else if (hit && strb.doRead)  tapeQ[c] <= 1'b0;
      else if (hit && strb.doWrite) tapeQ[c] <= strb.wrVal;
    end
  end

  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doInc && !atLast) |=> (headQ == $past(headQ) + 1'b1));
  p_hwm_cover_r2: assert property (@(posedge clk) disable iff (!rstN)
    hwmQ >= headQ);
  p_dec_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doDec && atFirst) |=> (headQ == '0));
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRead |=> (curBit == 1'b0));
endmodule

// File: rtl/tape_ctrl.sv
module tape_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdInc,
  input  logic                   cmdDec,
  input  logic                   cmdRead,
  input  logic                   cmdSet,
  input  logic                   cmdReset,
  input  logic                   atFirst,
  input  logic                   atLast,
  input  logic                   nextFresh,
  input  logic                   curBit,
  output tape_pkg::tape_strobe_t strb,
  output logic                   resValid,
  output logic                   resNz,
  output logic                   ovfFlag,
  output logic                   protoErr
);
  import tape_pkg::*;

  logic [NUM_CMDS-1:0] reqVec, winVec;
  logic pendQ, wrReq, resNext;

  assign reqVec[CMD_INC] = cmdInc;
  assign reqVec[CMD_DEC] = cmdDec;
  assign reqVec[CMD_RD]  = cmdRead;
  assign reqVec[CMD_SET] = cmdSet;
  assign reqVec[CMD_CLR] = cmdReset;

  // fixed priority: lowest index wins
  for (genvar k = 0; k < NUM_CMDS; k++) begin : g_pick
    if (k == 0) begin : g_first
      assign winVec[k] = reqVec[k];
    end else begin : g_rest
      assign winVec[k] = reqVec[k] && !(|reqVec[k-1:0]);
    end
  end

  assign wrReq        = winVec[CMD_SET] || winVec[CMD_CLR];
  assign strb.doInc   = winVec[CMD_INC];
  assign strb.doDec   = winVec[CMD_DEC];
  assign strb.doRead  = winVec[CMD_RD];
  assign strb.doWrite = wrReq && pendQ;
  assign strb.wrVal   = winVec[CMD_SET];

  always_comb begin
    resNext = 1'b0;
    if (winVec[CMD_INC])      resNext = !atLast && nextFresh;
    else if (winVec[CMD_DEC]) resNext = !atFirst;
    else if (winVec[CMD_RD])  resNext = curBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= 1'b0;
      resValid <= 1'b0;
      resNz    <= 1'b0;
      ovfFlag  <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      resValid <= winVec[CMD_INC] || winVec[CMD_DEC] || winVec[CMD_RD];
      resNz    <= resNext;
      if (winVec[CMD_RD])                          pendQ <= 1'b1;
      else if (wrReq || winVec[CMD_INC] || winVec[CMD_DEC]) pendQ <= 1'b0;
      if (winVec[CMD_INC] && atLast) ovfFlag  <= 1'b1;
      if (wrReq && !pendQ)           protoErr <= 1'b1;
    end
  end

  p_valid_due_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdInc || cmdDec || cmdRead) |=> resValid);
  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdInc || cmdDec || cmdRead) |=> !resValid);
  p_sat_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doInc && atLast) |=> (ovfFlag && !resNz));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
  p_win_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doInc, strb.doDec, strb.doRead, wrReq}));
endmodule

// File: rtl/tape_head_reg.sv
module tape_head_reg #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdInc,
  input  logic          cmdDec,
  input  logic          cmdRead,
  input  logic          cmdSet,
  input  logic          cmdReset,
  output logic          resValid,
  output logic          resNz,
  output logic [AW-1:0] headPos,
  output logic          ovfFlag,
  output logic          protoErr
);
  tape_pkg::tape_strobe_t strb;
  logic atFirst, atLast, nextFresh, curBit;

  tape_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdInc(cmdInc), .cmdDec(cmdDec), .cmdRead(cmdRead),
    .cmdSet(cmdSet), .cmdReset(cmdReset),
    .atFirst(atFirst), .atLast(atLast), .nextFresh(nextFresh), .curBit(curBit),
    .strb(strb), .resValid(resValid), .resNz(resNz),
    .ovfFlag(ovfFlag), .protoErr(protoErr)
  );

  tape_dpath #(.DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .headPos(headPos), .atFirst(atFirst), .atLast(atLast),
    .nextFresh(nextFresh), .curBit(curBit)
  );
endmodule

// File: tb/tape_head_reg_tb_top.sv
module tape_head_reg_tb_top;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  // command codes: 0 idle, 1 inc, 2 dec, 3 read, 4 set, 5 reset
  localparam int NV = 16;
  // vector: cmd[8:6] expValid[5] expNz[4] expHead[3:1] expErr[0]
  localparam logic [8:0] VEC [NV] = '{
    {3'd2, 1'b1, 1'b0, 3'd0, 1'b0},  // R4 dec at 0
    {3'd3, 1'b1, 1'b0, 3'd0, 1'b0},  // R5 read 0
    {3'd4, 1'b0, 1'b0, 3'd0, 1'b0},  // R7 set
    {3'd3, 1'b1, 1'b1, 3'd0, 1'b0},  // R5 read 1
    {3'd3, 1'b1, 1'b0, 3'd0, 1'b0},  // R6 cleared
    {3'd5, 1'b0, 1'b0, 3'd0, 1'b0},  // R7 reset
    {3'd1, 1'b1, 1'b1, 3'd1, 1'b0},  // R2 fresh
    {3'd3, 1'b1, 1'b0, 3'd1, 1'b0},
    {3'd4, 1'b0, 1'b0, 3'd1, 1'b0},
    {3'd2, 1'b1, 1'b1, 3'd0, 1'b0},  // R4 move back
    {3'd1, 1'b1, 1'b0, 3'd1, 1'b0},  // R2 not fresh
    {3'd1, 1'b1, 1'b1, 3'd2, 1'b0},  // R2 fresh
    {3'd0, 1'b0, 1'b0, 3'd2, 1'b0},  // R9 idle
    {3'd2, 1'b1, 1'b1, 3'd1, 1'b0},
    {3'd3, 1'b1, 1'b1, 3'd1, 1'b0},  // R5 stored 1
    {3'd5, 1'b0, 1'b0, 3'd1, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdInc = 0, cmdDec = 0, cmdRead = 0, cmdSet = 0, cmdReset = 0;
  logic resValid, resNz, ovfFlag, protoErr;
  logic [AW-1:0] headPos;
  int testCnt = 0, failCnt = 0;

  always #4 clk = ~clk;

  tape_head_reg #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .cmdInc(cmdInc), .cmdDec(cmdDec),
    .cmdRead(cmdRead), .cmdSet(cmdSet), .cmdReset(cmdReset),
    .resValid(resValid), .resNz(resNz), .headPos(headPos),
    .ovfFlag(ovfFlag), .protoErr(protoErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] m);  // {reset,set,read,dec,inc}
    @(negedge clk);
    {cmdReset, cmdSet, cmdRead, cmdDec, cmdInc} = m;
    @(negedge clk);
    {cmdReset, cmdSet, cmdRead, cmdDec, cmdInc} = '0;
  endtask

  function automatic logic [4:0] codeMask(input int c);
    return (c == 0) ? 5'b0 : 5'(1 << (c - 1));
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #1_000_000;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    doReset();
    check("R1 head", int'(headPos), 0);
    check("R1 valid", int'(resValid), 0);
    check("R1 ovf", int'(ovfFlag), 0);
    check("R1 err", int'(protoErr), 0);

    for (int i = 0; i < NV; i++) begin
      pulse(codeMask(int'(VEC[i][8:6])));
      check($sformatf("R9 vec%0d valid", i), int'(resValid), int'(VEC[i][5]));
      if (VEC[i][5]) check($sformatf("R2/R4/R5 vec%0d nz", i), int'(resNz), int'(VEC[i][4]));
      check($sformatf("R2/R4 vec%0d head", i), int'(headPos), int'(VEC[i][3:1]));
      check($sformatf("R8 vec%0d err", i), int'(protoErr), int'(VEC[i][0]));
    end

    // R3: walk to last cell then one more
    for (int i = 0; i < DEPTH - 2; i++) pulse(5'b00001);
    check("R3 reached last", int'(headPos), DEPTH - 1);
    check("R3 no ovf yet", int'(ovfFlag), 0);
    pulse(5'b00001);
    check("R3 saturate head", int'(headPos), DEPTH - 1);
    check("R3 result Z", int'(resNz), 0);
    check("R3 ovf set", int'(ovfFlag), 1);
    pulse(5'b00100);
    check("R1 fresh cell zero", int'(resNz), 0);
    pulse(5'b01000);
    pulse(5'b00100);
    check("R5 last cell 1", int'(resNz), 1);
    // R8: pending read cancelled by moves
    pulse(5'b00010);
    pulse(5'b00001);
    check("R8 no err yet", int'(protoErr), 0);
    pulse(5'b01000);
    check("R8 err raised", int'(protoErr), 1);
    check("R7 write no valid", int'(resValid), 0);
    pulse(5'b00100);
    check("R8 ignored write", int'(resNz), 0);
    check("R3 ovf sticky", int'(ovfFlag), 1);

    // R10 priority
    doReset();
    check("R1 flags cleared", int'(ovfFlag | protoErr), 0);
    pulse(5'b00011);
    check("R10 inc over dec", int'(headPos), 1);
    check("R10 inc result", int'(resNz), 1);
    pulse(5'b00101);
    check("R10 inc over read", int'(headPos), 2);
    pulse(5'b11100);
    check("R10 read over writes", int'(resValid), 1);
    check("R10 read value", int'(resNz), 0);
    pulse(5'b11000);
    check("R10 set over reset err", int'(protoErr), 0);
    pulse(5'b00100);
    check("R10 set won", int'(resNz), 1);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule